// File: doc/BRIEF.md
# Six-Bit Divide-by-Ten Unit

This block divides a 6-bit unsigned value (0 to 63) by ten and returns both the quotient (0 to 6) and the remainder (0 to 9). It does not subtract ten over and over. Instead it decodes which of seven decades the value lies in, and that decode gives the quotient at once. The same decode selects a precomputed multiple of ten. An adder subtracts that multiple by adding its ones' complement with a carry-in of one, and the remainder is the low four bits of the sum. The active decade is also brought out as a 7-bit one-hot diagnostic vector.

The divider core is purely combinational. A parameter chooses between two forms of the top. In the default form, one register stage with a valid flag wraps the core. In the other form, the results pass straight through, and the valid flag is a copy of the input strobe. The unit is meant as a digit-extraction step in decimal conversion datapaths.

Top module: `div10_unit`

## Requirements
- R1: For a dividend below 60, the quotient is the integer part of dividend/10, so the values 10k through 10k+9 give quotient k.
- R2: Any dividend from 60 to 63 gives quotient 6.
- R3: The remainder equals dividend minus ten times the quotient and is always in the range 0 to 9.
- R4: The diagnostic vector has exactly one bit set for every result. Bit k (k = 0..5) marks the range 10k to 10k+9, and bit 6 marks 60 to 63. The set bit's index equals the quotient.
- R5: In the registered form, quotient, remainder and diagnostic vector show the result for the dividend sampled on a clock edge where the input strobe was high. The output valid flag is high during the following cycle.
- R6: In the registered form, a clock edge with the input strobe low drops the output valid flag. Quotient, remainder and diagnostic vector keep their previous values, whatever the dividend does.
- R7: A synchronous active-low reset clears the valid flag, quotient, remainder and diagnostic vector to zero. It takes precedence over an input strobe on the same edge.
- R8: Dividend 0x3A gives quotient 5, remainder 8 and diagnostic bit 5. 0x31 gives 4 remainder 9, 0x3F gives 6 remainder 3, and 0x1E gives 3 remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe marking the dividend as valid |
| dividend | input | 6 | Unsigned dividend, 0 to 63 |
| out_valid | output | 1 | Result valid flag |
| quotient | output | 3 | Dividend divided by ten |
| remainder | output | 4 | Dividend modulo ten |
| decade_hot | output | 7 | One-hot marker of the active decade |

## Verification
Reset and the input strobe can land on the same clock edge, and the bench drives exactly that. It holds reset low while presenting a valid dividend. It then requires the valid flag and all result fields to read zero, rather than the quotient of the presented value. A second overlap arises when the strobe falls while the dividend keeps changing. The bench judges this by requiring the previous result to stay in place and the valid flag to drop. Every dividend 0 to 63 is streamed back to back. Each result is compared one cycle later against a model that uses integer division and modulo.

// File: rtl/div10_pkg.sv
// Package: shared widths for the divide-by-ten unit.
// Assumes an unsigned dividend no wider than the 0..63 range handled here.
package div10_pkg;
    localparam int DIV_W  = 6;                      // dividend width
    localparam int DIVSR  = 10;                     // constant divisor
    localparam int MAX_A  = (1 << DIV_W) - 1;       // largest dividend
    localparam int NDEC   = MAX_A / DIVSR + 1;      // number of decades
    localparam int Q_W    = $clog2(NDEC);           // quotient width
    localparam int R_W    = $clog2(DIVSR);          // remainder width
endpackage

// File: rtl/div10_decade_decode.sv
// Module: decodes which decade of ten the dividend falls in.
// Assumes the final decade absorbs every value from its base to MAX_A.
module div10_decade_decode
    import div10_pkg::*;
(
    input  logic [DIV_W-1:0] value,
    output logic [NDEC-1:0]  hot
);
    // One range comparator per decade; the last one is open-ended.
    for (genvar k = 0; k < NDEC; k++) begin : g_dec
        localparam int LO = k * DIVSR;
        localparam int HI = (k + 1) * DIVSR;
        if (k == NDEC - 1) begin : g_top
            assign hot[k] = (int'(value) >= LO);
        end else begin : g_mid
            assign hot[k] = (int'(value) >= LO) && (int'(value) < HI);
        end
    end
endmodule

// File: rtl/div10_multiple_enc.sv
// Module: turns the one-hot decade into the binary quotient and the
// ones' complement of ten times the quotient. Assumes a one-hot input.
module div10_multiple_enc
    import div10_pkg::*;
(
    input  logic [NDEC-1:0]  hot,
    output logic [Q_W-1:0]   quot,
    output logic [DIV_W-1:0] sub_n
);
    // Quotient bit b is set by every decade index k that has bit b set.
    for (genvar b = 0; b < Q_W; b++) begin : g_qbit
        logic [NDEC-1:0] mask;
        for (genvar k = 0; k < NDEC; k++) begin : g_qm
            assign mask[k] = ((k >> b) & 1) == 1;
        end
        assign quot[b] = |(hot & mask);
    end

    // Complemented subtrahend bit b is low whenever 10k has bit b set.
    for (genvar b = 0; b < DIV_W; b++) begin : g_sbit
        logic [NDEC-1:0] mask;
        for (genvar k = 0; k < NDEC; k++) begin : g_sm
            assign mask[k] = (((k * DIVSR) >> b) & 1) == 1;
        end
        assign sub_n[b] = ~|(hot & mask);
    end
endmodule

// File: rtl/div10_rem_adder.sv
// Module: forms dividend + complemented subtrahend + 1 and keeps the low
// remainder bits. Assumes the true difference fits in R_W bits.
module div10_rem_adder
    import div10_pkg::*;
(
    input  logic [DIV_W-1:0] value,
    input  logic [DIV_W-1:0] sub_n,
    output logic [R_W-1:0]   rem
);
    logic [DIV_W-1:0] sum;
    logic             unused_hi;

    // Two's-complement subtraction via carry-in of one.
    assign sum       = value + sub_n + DIV_W'(1);
    assign rem       = sum[R_W-1:0];
    assign unused_hi = ^sum[DIV_W-1:R_W];
endmodule

// File: rtl/div10_unit.sv
// Module: top of the divide-by-ten unit. REG_OUT=1 adds one output
// register stage with a valid flag; REG_OUT=0 passes results straight
// through. Assumes a synchronous active-low reset.
module div10_unit
    import div10_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [5:0]       dividend,
    output logic             out_valid,
    output logic [2:0]       quotient,
    output logic [3:0]       remainder,
    output logic [6:0]       decade_hot
);
    logic [NDEC-1:0]  hot_c;
    logic [Q_W-1:0]   quot_c;
    logic [DIV_W-1:0] sub_n_c;
    logic [R_W-1:0]   rem_c;

    div10_decade_decode u_decode (.value(dividend), .hot(hot_c));
    div10_multiple_enc  u_enc    (.hot(hot_c), .quot(quot_c), .sub_n(sub_n_c));
    div10_rem_adder     u_add    (.value(dividend), .sub_n(sub_n_c), .rem(rem_c));

    if (REG_OUT) begin : g_reg
        logic             v_q;
        logic [Q_W-1:0]   q_q;
        logic [R_W-1:0]   r_q;
        logic [NDEC-1:0]  h_q;

        // Capture results on a strobe, hold otherwise, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                q_q <= '0;
                r_q <= '0;
                h_q <= '0;
            end else begin
                v_q <= in_valid;
                if (in_valid) begin
                    q_q <= quot_c;
                    r_q <= rem_c;
                    h_q <= hot_c;
                end
            end
        end

        assign out_valid  = v_q;
        assign quotient   = q_q;
        assign remainder  = r_q;
        assign decade_hot = h_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign out_valid  = in_valid;
        assign quotient   = quot_c;
        assign remainder  = rem_c;
        assign decade_hot = hot_c;
    end
endmodule

// File: rtl/div10_unit_chk.sv
// Module: property checker for the registered form of div10_unit.
// Assumes it is bound to the top and sees its ports only.
module div10_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [5:0] dividend,
    input logic       out_valid,
    input logic [2:0] quotient,
    input logic [3:0] remainder,
    input logic [6:0] decade_hot
);
    if (REG_OUT) begin : g_props
        // R3: remainder stays within one decade.
        assert_rem_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> remainder <= 4'd9);

        // R4: exactly one decade marker is lit.
        assert_hot_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $countones(decade_hot) == 1);

        // R4: the lit marker agrees with the quotient.
        assert_hot_matches_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> decade_hot[quotient]);

        // R1: quotient and remainder rebuild the sampled dividend.
        assert_rebuild_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid)) |->
                (7'(quotient) * 7'd10 + 7'(remainder)) == 7'($past(dividend)));

        // R5: a strobe raises the valid flag on the next cycle.
        assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid)) |-> out_valid);

        // R6: without a strobe the result fields hold.
        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |->
                (!out_valid && $stable(quotient) && $stable(remainder) && $stable(decade_hot)));

        // R7: the cycle after reset shows cleared outputs.
        assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (!out_valid && quotient == 3'd0 && remainder == 4'd0
                               && decade_hot == 7'd0));
    end else begin : g_none
        logic unused_all;
        assign unused_all = ^{clk, rst_n, in_valid, dividend, out_valid,
                              quotient, remainder, decade_hot};
    end
endmodule

bind div10_unit div10_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(dividend),
    .out_valid(out_valid), .quotient(quotient), .remainder(remainder),
    .decade_hot(decade_hot)
);

// File: tb/div10_unit_tb_top.sv
// Bench: drives the registered divider and compares every cycle with a
// behavioural model built on integer divide and modulo.
module div10_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] dividend = '0;
    logic       out_valid;
    logic [2:0] quotient;
    logic [3:0] remainder;
    logic [6:0] decade_hot;

    int n_vec  = 0;
    int n_fail = 0;

    // Model state
    int m_v = 0, m_q = 0, m_r = 0, m_h = 0;

    div10_unit #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(dividend),
        .out_valid(out_valid), .quotient(quotient), .remainder(remainder),
        .decade_hot(decade_hot)
    );

    // 100 MHz clock
    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the model; tag names the requirement.
    task automatic compare(input string req);
        chk(req, "out_valid",  int'(out_valid),  m_v);
        chk(req, "quotient",   int'(quotient),   m_q);
        chk(req, "remainder",  int'(remainder),  m_r);
        chk(req, "decade_hot", int'(decade_hot), m_h);
    endtask

    // One cycle: drive at negedge, model updates at posedge, compare at next negedge.
    task automatic step(input logic rst_v, input logic v, input int a, input string req);
        rst_n    = rst_v;
        in_valid = v;
        dividend = 6'(a);
        @(posedge clk);
        if (!rst_v) begin
            m_v = 0; m_q = 0; m_r = 0; m_h = 0;
        end else begin
            m_v = v ? 1 : 0;
            if (v) begin
                m_q = a / 10;
                m_r = a % 10;
                m_h = 1 << (a / 10);
            end
        end
        @(negedge clk);
        compare(req);
    endtask

    // Watchdog
    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R7: reset state
        step(1'b0, 1'b0, 0, "R7");
        step(1'b0, 1'b1, 45, "R7");
        // R1 R2 R3 R4 R5: sweep every dividend back to back
        for (int a = 0; a < 64; a++) begin
            step(1'b1, 1'b1, a, (a >= 60) ? "R2" : "R1/R3/R4/R5");
        end
        // R6: strobe low while the dividend moves
        step(1'b1, 1'b0, 5, "R6");
        step(1'b1, 1'b0, 17, "R6");
        step(1'b1, 1'b0, 62, "R6");
        // R8: worked examples
        step(1'b1, 1'b1, 'h3A, "R8");
        chk("R8", "hot bit5", int'(decade_hot[5]), 1);
        step(1'b1, 1'b1, 'h31, "R8");
        step(1'b1, 1'b1, 'h3F, "R8");
        step(1'b1, 1'b1, 'h1E, "R8");
        // R7: reset dominates a simultaneous strobe
        step(1'b0, 1'b1, 59, "R7");
        // R5 after reset, then alternating strobe (R6)
        for (int a = 63; a >= 0; a -= 7) begin
            step(1'b1, 1'b1, a, "R5");
            step(1'b1, 1'b0, 63 - a, "R6");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule